// File: doc/BRIEF.md
# Keyed Indirect Coefficient Loader

This block sits behind a byte-serial register interface and guards a small bank of mixer gain coefficients. Software cannot write a coefficient directly. It first writes a 32-bit key to a key register. It then writes a 32-bit address word that names one of four coefficient slots. Last, it writes a 64-bit data word whose low 26 bits carry the gain. When all three frames arrive in that order and are well formed, the block issues a single commit pulse that carries the slot index and the value. The coefficient store downstream takes that pulse as its write enable.

Each register write arrives as one frame. A one-cycle `frmStart` strobe carries the subaddress. Data bytes follow, most significant byte first, each qualified by `byteValid`. A one-cycle `frmEnd` strobe closes the frame. The block checks each frame when it closes. A malformed frame, or a frame that arrives out of order, aborts the sequence and sets a sticky error flag. After a successful commit the block locks again, so every coefficient needs a fresh key.

The gain is a signed fixed-point number with 3 integer bits and 23 fraction bits. Unity gain is 0x0800000.

Top module: `coefw_port`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the locked state, clears `errFlag` and holds `coefWrEn` low. A sequence that is under way when reset arrives is forgotten.
- R2: A frame to subaddress 0xF8 with exactly 4 bytes equal to 0xA5,0xA5,0xA5,0xA5 unlocks the block. Such a frame is accepted in any state and restarts the sequence at the unlocked step. Any other content in a 0xF8 frame sets `errFlag` and locks the block.
- R3: A frame to subaddress 0xF9 is accepted only directly after an accepted key. It must have 4 bytes: three zero bytes, then an index byte equal to 0x96, 0x99, 0xA9 or 0xAA. A nonzero padding byte, any other index, or a frame in the wrong state sets `errFlag` and locks the block.
- R4: A frame to subaddress 0xFA is accepted only directly after an accepted address. It must have 8 bytes sent MSB first, with bits 63..26 all zero. Bits 25..0 are the value. A frame that breaks any of these rules sets `errFlag`, locks the block and produces no commit.
- R5: An accepted 0xFA frame raises `coefWrEn` for exactly one cycle, on the clock edge that samples `frmEnd`. During that cycle `coefIdx` holds the latched index and `coefVal` holds the 26-bit value.
- R6: After a commit the block is locked. A further address or data frame sent without a new key sets `errFlag`.
- R7: A 0xF8 or 0xF9 frame whose byte count is not 4, or a 0xFA frame whose byte count is not 8, is discarded. It sets `errFlag` and locks the block.
- R8: A frame to any subaddress other than 0xF8, 0xF9 and 0xFA cancels a pending sequence without setting `errFlag`.
- R9: `errFlag` is sticky. Once set, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frmStart | input | 1 | Frame start strobe; qualifies `subAddr` |
| subAddr | input | 8 | Register subaddress of the frame |
| byteValid | input | 1 | Qualifies `byteData` |
| byteData | input | 8 | Frame payload byte, most significant byte first |
| frmEnd | input | 1 | Frame end strobe; the frame is checked in this cycle |
| coefWrEn | output | 1 | One-cycle coefficient commit pulse |
| coefIdx | output | 8 | Index of the coefficient being committed |
| coefVal | output | 26 | Committed coefficient value (signed, 3.23 format) |
| errFlag | output | 1 | Sticky sequence/format error flag |

## Verification
The loader is tried with complete key–address–data sequences for each of the four legal indices. The values include unity, the all-ones 26-bit pattern and two typical gains, which shows that every value bit and index bit reaches the commit. The same sequences are then broken one way at a time, to tell each rejection rule apart: a wrong key, an illegal index, nonzero address padding, a set bit 26 in the data, short and long frames, steps out of order, a repeated key, a foreign subaddress mid-sequence, and an address or data frame after a commit. Each case is judged at the ports by the presence of a commit and the state of the error flag.

// File: rtl/coefw_pkg.sv
package coefw_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int DATA_BYTES = 8;
  localparam int COEF_W     = 26;
  localparam int IDX_W      = 8;
  localparam int DATA_W     = DATA_BYTES * BYTE_W;
  localparam int WORD_W     = WORD_BYTES * BYTE_W;
  localparam int CNT_MAX    = DATA_BYTES + 1;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  localparam logic [BYTE_W-1:0] SUB_KEY  = 8'hF8;
  localparam logic [BYTE_W-1:0] SUB_ADDR = 8'hF9;
  localparam logic [BYTE_W-1:0] SUB_DATA = 8'hFA;
  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'hA5A5_A5A5;

  localparam int NUM_LEGAL = 4;
  localparam logic [IDX_W-1:0] LEGAL_IDX [NUM_LEGAL] = '{8'h96, 8'h99, 8'hA9, 8'hAA};

  typedef enum logic [1:0] {
    ST_LOCKED    = 2'd0,
    ST_KEYED     = 2'd1,
    ST_ADDRESSED = 2'd2
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchIdx;
    logic commit;
  } ctrl_strobe_t;

  // frame decode results from datapath to control
  typedef struct packed {
    logic isKey;
    logic isAddr;
    logic isData;
    logic lenWordOk;
    logic lenDataOk;
    logic keyMatch;
    logic addrPadOk;
    logic idxLegal;
    logic dataPadOk;
  } frame_info_t;
endpackage

// File: rtl/coefw_datapath.sv
module coefw_datapath
  import coefw_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                frmStart,
  input  logic [BYTE_W-1:0]   subAddr,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData,
  input  ctrl_strobe_t        strobe,
  output frame_info_t         info,
  output logic                coefWrEn,
  output logic [IDX_W-1:0]    coefIdx,
  output logic [COEF_W-1:0]   coefVal
);
  logic [BYTE_W-1:0] subReg;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  byteCnt;
  logic [IDX_W-1:0]  idxReg;
  logic [NUM_LEGAL-1:0] idxHit;

  // frame capture: shift MSB first, count saturates one past the longest frame
  always_ff @(posedge clk) begin
    if (rst) begin
      subReg   <= '0;
      shiftReg <= '0;
      byteCnt  <= '0;
    end else if (frmStart) begin
      subReg   <= subAddr;
      shiftReg <= '0;
      byteCnt  <= '0;
    end else if (byteValid) begin
      shiftReg <= {shiftReg[DATA_W-BYTE_W-1:0], byteData};
      if (byteCnt != CNT_W'(CNT_MAX)) byteCnt <= byteCnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LEGAL; g++) begin : g_idx
    assign idxHit[g] = (shiftReg[IDX_W-1:0] == LEGAL_IDX[g]);
  end

  always_comb begin
    info.isKey     = (subReg == SUB_KEY);
    info.isAddr    = (subReg == SUB_ADDR);
    info.isData    = (subReg == SUB_DATA);
    info.lenWordOk = (byteCnt == CNT_W'(WORD_BYTES));
    info.lenDataOk = (byteCnt == CNT_W'(DATA_BYTES));
    info.keyMatch  = (shiftReg[WORD_W-1:0] == UNLOCK_KEY);
    info.addrPadOk = (shiftReg[WORD_W-1:IDX_W] == '0);
    info.idxLegal  = |idxHit;
    info.dataPadOk = (shiftReg[DATA_W-1:COEF_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idxReg   <= '0;
      coefWrEn <= 1'b0;
      coefIdx  <= '0;
      coefVal  <= '0;
    end else begin
      if (strobe.latchIdx) idxReg <= shiftReg[IDX_W-1:0];
      coefWrEn <= strobe.commit;
      if (strobe.commit) begin
        coefIdx <= idxReg;
        coefVal <= shiftReg[COEF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/coefw_ctrl.sv
module coefw_ctrl
  import coefw_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         frmEnd,
  input  frame_info_t  info,
  output ctrl_strobe_t strobe,
  output logic         errFlag
);
  seq_state_t state, nextState;
  logic       flagErr;

  always_comb begin
    nextState = state;
    strobe    = '0;
    flagErr   = 1'b0;
    if (frmEnd) begin
      if (info.isKey) begin
        if (info.lenWordOk && info.keyMatch) nextState = ST_KEYED;
        else begin nextState = ST_LOCKED; flagErr = 1'b1; end
      end else if (info.isAddr) begin
        if (state == ST_KEYED && info.lenWordOk && info.addrPadOk && info.idxLegal) begin
          nextState       = ST_ADDRESSED;
          strobe.latchIdx = 1'b1;
        end else begin
          nextState = ST_LOCKED; flagErr = 1'b1;
        end
      end else if (info.isData) begin
        nextState = ST_LOCKED;
        if (state == ST_ADDRESSED && info.lenDataOk && info.dataPadOk) strobe.commit = 1'b1;
        else flagErr = 1'b1;
      end else begin
        nextState = ST_LOCKED;   // foreign subaddress cancels quietly
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LOCKED;
      errFlag <= 1'b0;
    end else begin
      state   <= nextState;
      errFlag <= errFlag | flagErr;
    end
  end
endmodule

// File: rtl/coefw_port.sv
module coefw_port
  import coefw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frmStart,
  input  logic [7:0]        subAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              frmEnd,
  output logic              coefWrEn,
  output logic [7:0]        coefIdx,
  output logic [25:0]       coefVal,
  output logic              errFlag
);
  ctrl_strobe_t strobe;
  frame_info_t  info;

  coefw_datapath dp_i (
    .clk(clk), .rst(rst), .frmStart(frmStart), .subAddr(subAddr),
    .byteValid(byteValid), .byteData(byteData), .strobe(strobe), .info(info),
    .coefWrEn(coefWrEn), .coefIdx(coefIdx), .coefVal(coefVal)
  );

  coefw_ctrl ctrl_i (
    .clk(clk), .rst(rst), .frmEnd(frmEnd), .info(info),
    .strobe(strobe), .errFlag(errFlag)
  );
endmodule

// File: rtl/coefw_port_chk.sv
module coefw_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        frmEnd,
  input logic        coefWrEn,
  input logic [7:0]  coefIdx,
  input logic        errFlag
);
  p_pulse_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    coefWrEn |=> !coefWrEn);

  p_commit_after_end_r5: assert property (@(posedge clk) disable iff (rst)
    coefWrEn |-> $past(frmEnd));

  p_legal_index_r3: assert property (@(posedge clk) disable iff (rst)
    coefWrEn |-> (coefIdx == 8'h96 || coefIdx == 8'h99 ||
                  coefIdx == 8'hA9 || coefIdx == 8'hAA));

  p_error_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  p_no_commit_with_error_r4: assert property (@(posedge clk) disable iff (rst)
    coefWrEn |-> (errFlag == $past(errFlag)));

  p_error_only_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(errFlag) |-> $past(frmEnd));
endmodule

bind coefw_port coefw_port_chk chk_i (
  .clk(clk), .rst(rst), .frmEnd(frmEnd), .coefWrEn(coefWrEn),
  .coefIdx(coefIdx), .errFlag(errFlag)
);

// File: tb/coefw_port_tb.sv
`timescale 1ns/1ps
module coefw_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frmStart = 1'b0, byteValid = 1'b0, frmEnd = 1'b0;
  logic [7:0] subAddr = '0, byteData = '0;
  logic coefWrEn, errFlag;
  logic [7:0] coefIdx;
  logic [25:0] coefVal;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  coefw_port dut_i (
    .clk(clk), .rst(rst), .frmStart(frmStart), .subAddr(subAddr),
    .byteValid(byteValid), .byteData(byteData), .frmEnd(frmEnd),
    .coefWrEn(coefWrEn), .coefIdx(coefIdx), .coefVal(coefVal), .errFlag(errFlag)
  );

  typedef struct packed {
    logic        rstB;
    logic [7:0]  sub;
    logic [3:0]  len;
    logic [63:0] data;
    logic        expWr;
    logic [7:0]  expIdx;
    logic [25:0] expVal;
    logic        expErr;
  } row_t;

  localparam int NROWS = 42;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0}, // R2 key
    '{1'b0, 8'hF9, 4'd4, 64'h96,                1'b0, 8'h00, 26'h0,       1'b0}, // R3
    '{1'b0, 8'hFA, 4'd8, 64'h800000,            1'b1, 8'h96, 26'h0800000, 1'b0}, // R5 unity
    '{1'b0, 8'hF9, 4'd4, 64'h99,                1'b0, 8'h00, 26'h0,       1'b1}, // R6 relocked
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'hAA,                1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hFA, 4'd8, 64'h3FFFFFF,           1'b1, 8'hAA, 26'h3FFFFFF, 1'b0}, // R4 all ones
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'hA9,                1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hFA, 4'd8, 64'hE39EA8,            1'b1, 8'hA9, 26'h0E39EA8, 1'b0},
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'h99,                1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hFA, 4'd8, 64'h47FACC,            1'b1, 8'h99, 26'h047FACC, 1'b0},
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A4,          1'b0, 8'h00, 26'h0,       1'b1}, // R2 bad key
    '{1'b0, 8'hF9, 4'd4, 64'h96,                1'b0, 8'h00, 26'h0,       1'b1},
    '{1'b0, 8'hFA, 4'd8, 64'h800000,            1'b0, 8'h00, 26'h0,       1'b1}, // R9 sticky
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'h97,                1'b0, 8'h00, 26'h0,       1'b1}, // R3 illegal
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'h01000096,          1'b0, 8'h00, 26'h0,       1'b1}, // R3 pad
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'h96,                1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hFA, 4'd8, 64'h4000000,           1'b0, 8'h00, 26'h0,       1'b1}, // R4 pad bit 26
    '{1'b1, 8'hF8, 4'd3, 64'hA5A5A5,            1'b0, 8'h00, 26'h0,       1'b1}, // R7 short key
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd5, 64'h96,                1'b0, 8'h00, 26'h0,       1'b1}, // R7 long addr
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'h96,                1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hFA, 4'd7, 64'h800000,            1'b0, 8'h00, 26'h0,       1'b1}, // R7 short data
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'h07, 4'd1, 64'h12,                1'b0, 8'h00, 26'h0,       1'b0}, // R8 foreign
    '{1'b0, 8'hF9, 4'd4, 64'h96,                1'b0, 8'h00, 26'h0,       1'b1}, // R8 cancelled
    '{1'b1, 8'hF9, 4'd4, 64'h96,                1'b0, 8'h00, 26'h0,       1'b1}, // R3 no key
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'h96,                1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0}, // R2 restart
    '{1'b0, 8'hFA, 4'd8, 64'h800000,            1'b0, 8'h00, 26'h0,       1'b1}, // R4 order
    '{1'b1, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF8, 4'd4, 64'hA5A5A5A5,          1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hF9, 4'd4, 64'hA9,                1'b0, 8'h00, 26'h0,       1'b0},
    '{1'b0, 8'hFA, 4'd8, 64'h1,                 1'b1, 8'hA9, 26'h1,       1'b0},
    '{1'b0, 8'hFA, 4'd8, 64'h1,                 1'b0, 8'h00, 26'h0,       1'b1}  // R6 data w/o key
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
    check("R1 errFlag after reset", 64'(errFlag), 64'd0);
    check("R1 coefWrEn after reset", 64'(coefWrEn), 64'd0);
  endtask

  // returns at the negedge after the edge that sampled frmEnd
  task automatic sendFrame(input logic [7:0] sub, input int len, input logic [63:0] d);
    @(negedge clk) begin frmStart = 1'b1; subAddr = sub; end
    @(negedge clk) frmStart = 1'b0;
    for (int i = len - 1; i >= 0; i--) begin
      byteValid = 1'b1;
      byteData  = (i < 8) ? d[i*8 +: 8] : 8'h00;
      @(negedge clk);
    end
    byteValid = 1'b0;
    frmEnd = 1'b1;
    @(negedge clk) frmEnd = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    doReset();
    for (int r = 0; r < NROWS; r++) begin
      if (ROWS[r].rstB) doReset();
      sendFrame(ROWS[r].sub, int'(ROWS[r].len), ROWS[r].data);
      check($sformatf("R5 row %0d commit", r), 64'(coefWrEn), 64'(ROWS[r].expWr));
      check($sformatf("R9 row %0d errFlag", r), 64'(errFlag), 64'(ROWS[r].expErr));
      if (ROWS[r].expWr) begin
        check($sformatf("R5 row %0d index", r), 64'(coefIdx), 64'(ROWS[r].expIdx));
        check($sformatf("R4 row %0d value", r), 64'(coefVal), 64'(ROWS[r].expVal));
        @(negedge clk);
        check($sformatf("R5 row %0d pulse width", r), 64'(coefWrEn), 64'd0);
      end
    end

    // R1: reset in the middle of a sequence forgets it
    doReset();
    sendFrame(8'hF8, 4, 64'hA5A5A5A5);
    sendFrame(8'hF9, 4, 64'h96);
    doReset();
    sendFrame(8'hFA, 8, 64'h800000);
    check("R1 no commit after mid-sequence reset", 64'(coefWrEn), 64'd0);
    check("R1 error after mid-sequence reset", 64'(errFlag), 64'd1);

    // R8: foreign subaddress between address and data cancels, no error
    doReset();
    sendFrame(8'hF8, 4, 64'hA5A5A5A5);
    sendFrame(8'hF9, 4, 64'hAA);
    sendFrame(8'h20, 2, 64'h1234);
    check("R8 foreign frame no error", 64'(errFlag), 64'd0);
    sendFrame(8'hFA, 8, 64'h800000);
    check("R8 data after cancel no commit", 64'(coefWrEn), 64'd0);
    check("R8 data after cancel flags error", 64'(errFlag), 64'd1);

    // R7: 9-byte data frame is rejected
    doReset();
    sendFrame(8'hF8, 4, 64'hA5A5A5A5);
    sendFrame(8'hF9, 4, 64'h99);
    sendFrame(8'hFA, 9, 64'h800000);
    check("R7 long data no commit", 64'(coefWrEn), 64'd0);
    check("R7 long data error", 64'(errFlag), 64'd1);

    finish();
  end
endmodule